// File: doc/BRIEF.md
# Pipelined Equality Comparator Tree

This block reports whether two wide operands carry the same bit pattern. The answer appears a fixed number of register stages after the operands are taken in. Between the inputs and the output, the comparison is built as a tree. At each stage the remaining bits are cut into contiguous sub-ranges, and each sub-range is handled by a child subtree one stage shorter. The stage then registers the AND of its children's flags. The bottom stage compares its bits directly. It groups them so that each notional lookup table of `LUTSIZE` inputs sees `LUTSIZE/2` bit pairs, so an odd count leaves one input idle.

The cut at each stage is fixed at elaboration time from `WIDTH`, `DEPTH` and `LUTSIZE`. The aim is to spread the reduction logic evenly over the stages. First, the total logic depth of the whole tree is worked out, allowing for the leaves reading two buses. That depth is then shared across the stages. If a stage could defer all of its work to the stages below without making them deeper, it is kept as a plain register with a single child. This avoids half-filled tables when more pipelining is requested than the width needs.

The operands arrive as a valid/ready stream and the result leaves as one. The pipeline moves as a whole. Every stage advances in a cycle where the output is empty or the consumer accepts it. When the consumer holds `out_ready` low on a valid result, every stage freezes and `in_ready` drops. A result is consumed on a cycle with both `out_valid` and `out_ready` high. An operand pair is taken on a cycle with both `in_valid` and `in_ready` high.

Top module: `eq_tree_cmp`

## Requirements
- R1: A synchronous active-high `rst` leaves `out_valid` low on the following cycles, both while it is held and after a one-cycle pulse that discards pairs already in flight.
- R2: For an accepted pair, `out_equal` is 1 exactly when every bit of `in_a` matches the same bit of `in_b`, and 0 otherwise.
- R3: With `out_ready` held high, the result for a pair taken at a clock edge appears on `out_valid`/`out_equal` after exactly `DEPTH` edges, counting that edge. `out_valid` is low on the cycles before it, and back-to-back pairs yield back-to-back results in order.
- R4: A pair that differs in a single bit gives `out_equal` = 0, whichever bit from 0 to `WIDTH-1` it is, including bits in the last, shorter sub-range.
- R5: While `out_valid` is high and `out_ready` is low, `out_valid` and `out_equal` hold their values and `in_ready` is low. The held result and the one queued behind it come out in order once `out_ready` rises.
- R6: `in_ready` is high on every cycle where `out_valid` is low or `out_ready` is high.
- R7: Cycles with `in_valid` low produce no result: `out_valid` stays low whatever the data inputs do.
- R8: R2 and R3 hold for every legal parameter set (`WIDTH` ≥ 1, `DEPTH` ≥ 1, `LUTSIZE` ≥ 2), including odd `LUTSIZE`, `DEPTH` = 1, and depths large enough that some stages act as plain registers.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high; clears valid state |
| in_valid | input | 1 | Operand pair present |
| in_ready | output | 1 | Pipeline can take a pair this cycle |
| in_a | input | WIDTH | First operand |
| in_b | input | WIDTH | Second operand |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes the result this cycle |
| out_equal | output | 1 | 1 when the operands of the result were identical |

## Verification
Identical operands (all zeros, all ones, alternating and random patterns) must return 1. Operands with a single flipped bit, walked across every position, must return 0; these show that no sub-range, including the short tail one, is dropped from the reduction. Random unrelated pairs and bursts of alternating match and mismatch separate the result of one pair from that of its neighbour, and so expose wrong latency or wrong ordering. Stalls, input bubbles and a mid-stream reset probe the stream handling. Three further instances with even and odd table sizes, a single stage, and an over-deep pipeline are compared every cycle against a delayed reference.

// File: rtl/eqt_pkg.sv
package eqt_pkg;

  // Ceiling used to keep power computations inside 64 bits.
  localparam longint SAT = 64'sd1 << 40;

  function automatic longint pow_sat(input int base, input int e);
    longint p;
    p = 1;
    for (int i = 0; i < e; i++) begin
      if (p >= SAT / base) p = SAT;
      else p = p * base;
    end
    return p;
  endfunction

  // Table levels needed per stage when the whole tree is spread over
  // 'depth' stages: smallest n with lut^(n*depth) >= leaf-adjusted work.
  function automatic int lvl_per_stage(input int depth, input int width, input int lut);
    longint work;
    longint step;
    longint reach;
    int     n;
    work  = (longint'(width) * 2 * lut) / (lut - (lut % 2));
    step  = pow_sat(lut, depth);
    reach = 1;
    n     = 0;
    while (reach < work) begin
      if (reach >= SAT / step) reach = SAT;
      else reach = reach * step;
      n++;
    end
    return n;
  endfunction

  // Bits handed to each child of a stage; equal to width when the stage
  // only registers (leaf, or deferring the work costs nothing).
  function automatic int child_span(input int depth, input int width, input int lut);
    int     n;
    int     k;
    longint mw;
    if (depth <= 1) return width;
    n = lvl_per_stage(depth, width, lut);
    if (n == lvl_per_stage(depth - 1, width, lut)) return width;
    k  = n * (depth - 1);
    mw = (pow_sat(lut, k) - longint'(lut % 2) * pow_sat(lut, k - 1)) / 2;
    if (mw < 1) mw = 1;
    if (mw > longint'(width)) mw = longint'(width);
    return int'(mw);
  endfunction

  function automatic int child_count(input int depth, input int width, input int lut);
    int s;
    s = child_span(depth, width, lut);
    return (width + s - 1) / s;
  endfunction

endpackage

// File: rtl/eqt_leaf.sv
module eqt_leaf #(
  parameter int W = 8,
  parameter int L = 6
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic         eq
);
  localparam int PAIRS  = (L / 2 < 1) ? 1 : L / 2;
  localparam int GROUPS = (W + PAIRS - 1) / PAIRS;

  logic [GROUPS-1:0] grp_eq;

  for (genvar g = 0; g < GROUPS; g++) begin : g_grp
    localparam int LO = g * PAIRS;
    localparam int HI = ((LO + PAIRS) < W) ? (LO + PAIRS - 1) : (W - 1);
    assign grp_eq[g] = (a[HI:LO] == b[HI:LO]);
  end

  assign eq = &grp_eq;
endmodule

// File: rtl/eqt_node.sv
module eqt_node #(
  parameter int W = 8,
  parameter int D = 1,
  parameter int L = 6
) (
  input  logic         clk,
  input  logic         en,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic         eq
);
  logic eq_q;
  logic eq_d;

  if (D <= 1) begin : g_leaf
    eqt_leaf #(.W(W), .L(L)) u_leaf (.a(a), .b(b), .eq(eq_d));
  end else begin : g_split
    localparam int SPAN = eqt_pkg::child_span(D, W, L);
    localparam int KIDS = eqt_pkg::child_count(D, W, L);
    logic [KIDS-1:0] kid_eq;

    for (genvar k = 0; k < KIDS; k++) begin : g_kid
      localparam int LO = k * SPAN;
      localparam int CW = ((W - LO) < SPAN) ? (W - LO) : SPAN;
      eqt_node #(.W(CW), .D(D - 1), .L(L)) u_kid (
        .clk (clk),
        .en  (en),
        .a   (a[LO+CW-1:LO]),
        .b   (b[LO+CW-1:LO]),
        .eq  (kid_eq[k])
      );
    end

    assign eq_d = &kid_eq;
  end

  always_ff @(posedge clk) begin
    if (en) eq_q <= eq_d;
  end

  assign eq = eq_q;
endmodule

// File: rtl/eqt_valid_pipe.sv
module eqt_valid_pipe #(
  parameter int D = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic en,
  input  logic vin,
  output logic vout
);
  logic [D-1:0] stg;

  always_ff @(posedge clk) begin
    if (rst) begin
      stg <= '0;
    end else if (en) begin
      stg[0] <= vin;
      for (int i = 1; i < D; i++) stg[i] <= stg[i-1];
    end
  end

  assign vout = stg[D-1];
endmodule

// File: rtl/eq_tree_cmp.sv
module eq_tree_cmp #(
  parameter int WIDTH   = 64,
  parameter int DEPTH   = 3,
  parameter int LUTSIZE = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [WIDTH-1:0] in_a,
  input  logic [WIDTH-1:0] in_b,
  output logic             out_valid,
  input  logic             out_ready,
  output logic             out_equal
);
  logic advance;

  assign advance  = out_ready | ~out_valid;
  assign in_ready = advance;

  eqt_node #(.W(WIDTH), .D(DEPTH), .L(LUTSIZE)) u_root (
    .clk (clk),
    .en  (advance),
    .a   (in_a),
    .b   (in_b),
    .eq  (out_equal)
  );

  eqt_valid_pipe #(.D(DEPTH)) u_vld (
    .clk  (clk),
    .rst  (rst),
    .en   (advance),
    .vin  (in_valid),
    .vout (out_valid)
  );
endmodule

// File: rtl/eq_tree_cmp_chk.sv
module eq_tree_cmp_chk #(
  parameter int DEPTH = 3
) (
  input logic clk,
  input logic rst,
  input logic in_valid,
  input logic in_ready,
  input logic out_valid,
  input logic out_ready,
  input logic out_equal
);
  logic in_fire;
  logic out_fire;
  int   inflight;

  assign in_fire  = in_valid & in_ready;
  assign out_fire = out_valid & out_ready;

  always_ff @(posedge clk) begin
    if (rst) inflight <= 0;
    else     inflight <= inflight + int'(in_fire) - int'(out_fire);
  end

  // R5
  stall_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_equal)));

  // R6
  ready_when_free_chk: assert property (@(posedge clk) disable iff (rst)
    (!in_ready) |-> (out_valid && !out_ready));

  // R3
  occupancy_bound_chk: assert property (@(posedge clk) disable iff (rst)
    inflight <= DEPTH);

  // R7
  no_phantom_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (inflight != 0));
endmodule

bind eq_tree_cmp eq_tree_cmp_chk #(.DEPTH(DEPTH)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_equal (out_equal)
);

// File: tb/sim_eq_tree_cmp.sv
module sim_eq_tree_cmp;
  localparam int CLK_PERIOD = 10;
  localparam int W  = 37;
  localparam int D0 = 3;
  localparam int L0 = 5;
  localparam int D1 = 2;
  localparam int L1 = 4;
  localparam int D2 = 5;
  localparam int L2 = 3;
  localparam int D3 = 1;
  localparam int L3 = 6;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic iv = 1'b0;
  logic ordy = 1'b1;
  logic [W-1:0] ia = '0;
  logic [W-1:0] ib = '0;

  logic irdy0, ov0, oe0;
  logic irdy1, ov1, oe1;
  logic irdy2, ov2, oe2;
  logic irdy3, ov3, oe3;

  int n_chk = 0;
  int n_bad = 0;
  int cyc = 0;
  bit rv [8] = '{default: 1'b0};
  bit re [8] = '{default: 1'b0};

  always #(CLK_PERIOD / 2) clk = ~clk;

  eq_tree_cmp #(.WIDTH(W), .DEPTH(D0), .LUTSIZE(L0)) u0 (
    .clk(clk), .rst(rst), .in_valid(iv), .in_ready(irdy0), .in_a(ia), .in_b(ib),
    .out_valid(ov0), .out_ready(ordy), .out_equal(oe0));
  eq_tree_cmp #(.WIDTH(W), .DEPTH(D1), .LUTSIZE(L1)) u1 (
    .clk(clk), .rst(rst), .in_valid(iv), .in_ready(irdy1), .in_a(ia), .in_b(ib),
    .out_valid(ov1), .out_ready(1'b1), .out_equal(oe1));
  eq_tree_cmp #(.WIDTH(W), .DEPTH(D2), .LUTSIZE(L2)) u2 (
    .clk(clk), .rst(rst), .in_valid(iv), .in_ready(irdy2), .in_a(ia), .in_b(ib),
    .out_valid(ov2), .out_ready(1'b1), .out_equal(oe2));
  eq_tree_cmp #(.WIDTH(W), .DEPTH(D3), .LUTSIZE(L3)) u3 (
    .clk(clk), .rst(rst), .in_valid(iv), .in_ready(irdy3), .in_a(ia), .in_b(ib),
    .out_valid(ov3), .out_ready(1'b1), .out_equal(oe3));

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [W-1:0] rnd();
    logic [63:0] t;
    t = {$urandom(), $urandom()};
    return t[W-1:0];
  endfunction

  function automatic logic [W-1:0] bit_at(input int i);
    return {{(W-1){1'b0}}, 1'b1} << i;
  endfunction

  // Reference model for u1..u3 (out_ready tied high): record per edge.
  always @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < 8; i++) rv[i] = 1'b0;
    end else begin
      rv[cyc % 8] = iv;
      re[cyc % 8] = (ia == ib);
    end
    cyc++;
  end

  task automatic side_check(input int d, input logic ov, input logic oe, input string tag);
    int idx;
    idx = (cyc - d) % 8;
    check(ov == rv[idx], {tag, " valid"}, ov, rv[idx]);
    if (rv[idx]) check(oe == re[idx], {tag, " equal"}, oe, re[idx]);
  endtask

  // R8: other configurations against the delayed reference, every cycle
  always @(negedge clk) begin
    if (cyc >= 8) begin
      side_check(D1, ov1, oe1, "R8 even lut d2");
      side_check(D2, ov2, oe2, "R8 odd lut deep");
      side_check(D3, ov3, oe3, "R8 single stage");
    end
  end

  // Push one pair, check R3 latency and R2 value.
  task automatic push_check(input logic [W-1:0] a, input logic [W-1:0] b, input string tag);
    logic exp;
    exp = (a == b);
    ordy = 1'b1;
    @(posedge clk); #1;
    iv = 1'b1; ia = a; ib = b;
    @(posedge clk); #1;
    iv = 1'b0; ia = rnd(); ib = rnd();
    for (int k = 0; k < D0 - 1; k++) begin
      @(negedge clk);
      check(ov0 == 1'b0, "R3 early valid", ov0, 0);
    end
    @(negedge clk);
    check(ov0 == 1'b1, "R3 valid at latency", ov0, 1);
    check(oe0 == exp, tag, oe0, exp);
  endtask

  task automatic t_reset();
    rst = 1'b1; iv = 1'b1; ia = rnd(); ib = ia;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      check(ov0 == 1'b0, "R1 valid in reset", ov0, 0);
      check(irdy0 == 1'b1, "R6 ready when empty", irdy0, 1);
    end
    @(posedge clk); #1;
    rst = 1'b0; iv = 1'b0;
    // mid-stream reset discards in-flight pairs
    @(posedge clk); #1;
    iv = 1'b1; ia = rnd(); ib = ia;
    @(posedge clk); #1;
    ia = rnd(); ib = ia;
    @(posedge clk); #1;
    iv = 1'b0; rst = 1'b1;
    @(posedge clk); #1;
    rst = 1'b0;
    for (int k = 0; k < D0 + 1; k++) begin
      @(negedge clk);
      check(ov0 == 1'b0, "R1 flushed by reset", ov0, 0);
    end
  endtask

  task automatic t_equal();
    logic [W-1:0] x;
    push_check('0, '0, "R2 zeros");
    push_check('1, '1, "R2 ones");
    x = {(W+1)/2{2'b10}};
    push_check(x, x, "R2 alternating");
    for (int k = 0; k < 4; k++) begin
      x = rnd();
      push_check(x, x, "R2 random same");
    end
  endtask

  task automatic t_single_bit();
    logic [W-1:0] x;
    for (int i = 0; i < W; i++) begin
      x = rnd();
      push_check(x, x ^ bit_at(i), $sformatf("R4 bit %0d", i));
    end
    push_check('0, bit_at(W-1), "R4 top bit from zero");
  endtask

  task automatic t_random();
    logic [W-1:0] x;
    for (int k = 0; k < 8; k++) begin
      x = rnd();
      push_check(x, rnd(), "R2 random pair");
    end
  endtask

  task automatic t_burst();
    logic [W-1:0] qa [8];
    logic [W-1:0] qb [8];
    for (int j = 0; j < 8; j++) begin
      qa[j] = rnd();
      qb[j] = (j % 2 == 1) ? qa[j] : (qa[j] ^ bit_at((j * 5) % W));
    end
    ordy = 1'b1;
    fork
      begin
        @(posedge clk); #1;
        for (int j = 0; j < 8; j++) begin
          iv = 1'b1; ia = qa[j]; ib = qb[j];
          @(posedge clk); #1;
        end
        iv = 1'b0;
      end
      begin
        @(posedge clk);
        @(posedge clk);
        repeat (D0 - 1) @(posedge clk);
        for (int j = 0; j < 8; j++) begin
          @(negedge clk);
          check(ov0 == 1'b1, "R3 burst valid", ov0, 1);
          check(oe0 == (j % 2 == 1), "R3 burst order", oe0, (j % 2 == 1));
        end
        @(negedge clk);
        check(ov0 == 1'b0, "R3 burst end", ov0, 0);
      end
    join
  endtask

  // Needs D0 >= 2: second pair is taken while the first is in flight.
  task automatic t_stall();
    logic [W-1:0] x;
    x = rnd();
    ordy = 1'b0;
    @(posedge clk); #1;
    iv = 1'b1; ia = x; ib = x;
    @(posedge clk); #1;
    ia = rnd(); ib = ~ia;
    @(posedge clk); #1;
    iv = 1'b0;
    repeat (D0 - 2) @(posedge clk);
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      ia = rnd(); ib = rnd();
      check(ov0 == 1'b1, "R5 held valid", ov0, 1);
      check(oe0 == 1'b1, "R5 held equal", oe0, 1);
      check(irdy0 == 1'b0, "R5 ready low", irdy0, 0);
      if (k < 3) @(posedge clk);
    end
    ordy = 1'b1;
    #1;
    check(irdy0 == 1'b1, "R6 ready on release", irdy0, 1);
    @(negedge clk);
    check(ov0 == 1'b1, "R5 queued valid", ov0, 1);
    check(oe0 == 1'b0, "R5 queued result", oe0, 0);
    @(negedge clk);
    check(ov0 == 1'b0, "R5 drained", ov0, 0);
  endtask

  task automatic t_bubble();
    ordy = 1'b1;
    iv = 1'b0;
    for (int k = 0; k < 8; k++) begin
      @(posedge clk); #1;
      ia = rnd(); ib = (k % 2 == 0) ? ia : rnd();
      @(negedge clk);
      check(ov0 == 1'b0, "R7 no result on bubble", ov0, 0);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    t_reset();
    t_equal();
    t_single_bit();
    t_random();
    t_burst();
    t_stall();
    t_bubble();
    repeat (8) @(posedge clk);
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule